// File: doc/BRIEF.md
# Audio Front-End Control Sequencer

This block sits between a control source and a write engine that drives the external latch registers of an audio front end. It holds shadow copies of the system-control register and the clock/routing register. It accepts one high-level setting at a time: input-pair mode, phantom power, hardware mute, internal sample rate, external clock source, or a raw clock-register restore. Each setting becomes zero, one or two register write requests, issued in the order the analog hardware needs. A relay always settles before the source selector moves, and the phantom supply voltage moves before its enable does.

After reset the block runs its own power-up sequence before it accepts commands. It also derives the codec speed-mode bits from the chosen internal rate, or from rate reports of the S/PDIF receiver while that receiver is the clock master. An error flag shows when the clock shadow claims an external sync source with no legal encoding.

Top module: `audio_ctl_sequencer`

## Requirements
- R1: After reset, before `cmdReady` rises, exactly four writes go out in this order: system-control (`wrSel`=0) 0x08, system-control 0x88, monitor (`wrSel`=1) 0x00, clock (`wrSel`=2) 0x00. `codecSpeed` is 0 from reset.
- R2: Opcode 0 sets the input-pair mode field, system-control bits [5:4]. Argument 0 selects line (00), 1 selects mic (01) and 2 selects mic with low-cut (11). Argument 3 is ignored. The field value 10 never appears in a system-control write.
- R3: A change to line is sent as two writes: first with bits [5:4] cleared, then with the relay (bit 0) also cleared. A change to a mic mode is sent as two writes: first with the relay set, then with the new field value.
- R4: Opcode 1 with argument bit 0 requests phantom on or off. The request acts only when it differs from the voltage bit (bit 1, 1 = 48 V). On: first a write with bit 1 set, then one with the active-low enable (bit 3) cleared. Off: first a write with bit 1 cleared, then one with bit 3 set.
- R5: Opcode 2 writes the hardware mute bit (bit 2, 1 = muted) from argument bit 0 in one system-control write.
- R6: Opcode 3 with argument 0..5 (44.1, 48, 88.2, 96, 176.4, 192 kHz) writes the clock register with bits [2:0] = argument and the sync bit (bit 3) cleared. All other bits are kept. Arguments 6 and 7 are ignored.
- R7: Opcode 4 selects an external source and sets the sync bit, with bits [2:0] and the word-select bit (bit 4) rewritten. Argument 0 (S/PDIF) gives 0x08, argument 1 (word clock 1x) gives 0x0A and argument 2 (word clock 256x) gives 0x1A in bits [4:0]. Argument 3 is ignored.
- R8: `codecSpeed` is 4'b1010 for rates above 108 kHz, 4'b0101 above 54 kHz and 0 otherwise. It follows an accepted internal-rate command. It also follows `extRateHz` on an `extRateValid` pulse, but only while clock bits [4:0] equal 0x08. A reported rate of 0 leaves it unchanged.
- R9: A command whose result equals the current shadow value issues no write, and `cmdReady` stays high.
- R10: A write request holds `wrValid`, `wrSel` and `wrData` steady until `wrReady` is seen. `cmdReady` is high only when no write is pending.
- R11: Opcode 5 writes the clock register with the full 8-bit argument. `clkCfgErr` is high whenever the clock shadow has bit 3 set and bits [4:0] are not 0x08, 0x0A or 0x1A.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmdValid | input | 1 | Command offered |
| cmdOp | input | 3 | Command opcode (0..5) |
| cmdArg | input | 8 | Command argument |
| cmdReady | output | 1 | Command accepted this cycle when high with cmdValid |
| extRateValid | input | 1 | Pulse: receiver reports a new input rate |
| extRateHz | input | HZ_W | Reported input rate in Hz (0 = unknown) |
| wrValid | output | 1 | Register write request pending |
| wrReady | input | 1 | Write engine takes the request |
| wrSel | output | 2 | Target register: 0 system, 1 monitor, 2 clock |
| wrData | output | 8 | Register value to write |
| codecSpeed | output | 4 | Codec speed-mode bits |
| clkCfgErr | output | 1 | Clock shadow holds an illegal external encoding |

## Verification
The assertions check four properties on every cycle: no system-control write carries the reserved mode code, the relay is set in any write that selects a mic source, a stalled request holds steady, and the speed bits stay one of the three legal codes. Only the bench scenarios can show the exact order and values of each write pair, that redundant or illegal commands issue nothing, and that receiver rate reports are used only in S/PDIF-master mode. The bench also shows the rate thresholds and the error flag across raw clock restores.

// File: rtl/audio_ctl_seq_pkg.sv
package audio_ctl_seq_pkg;

  localparam int REG_W      = 8;
  localparam int INIT_STEPS = 4;
  localparam int SLOT_W     = $clog2(INIT_STEPS);

  // system-control bit map (decoded by the analog board)
  localparam logic [REG_W-1:0] SYS_RELAY = 8'h01;
  localparam logic [REG_W-1:0] SYS_PVOLT = 8'h02;
  localparam logic [REG_W-1:0] SYS_MUTE  = 8'h04;
  localparam logic [REG_W-1:0] SYS_PHOFF = 8'h08;
  localparam logic [REG_W-1:0] SYS_SRC   = 8'h30;
  localparam logic [REG_W-1:0] SYS_PWRUP = 8'h80;

  // clock/routing bit map
  localparam logic [REG_W-1:0] CLK_RATE  = 8'h07;
  localparam logic [REG_W-1:0] CLK_SYNC  = 8'h08;
  localparam logic [REG_W-1:0] CLK_WSEL  = 8'h10;
  localparam logic [REG_W-1:0] CLK_KEY   = 8'h1F;
  localparam logic [REG_W-1:0] EXT_SPDIF = 8'h08;
  localparam logic [REG_W-1:0] EXT_WC1   = 8'h0A;
  localparam logic [REG_W-1:0] EXT_WC256 = 8'h1A;

  localparam logic [3:0] SPEED_NORMAL = 4'b0000;
  localparam logic [3:0] SPEED_DOUBLE = 4'b0101;
  localparam logic [3:0] SPEED_QUAD   = 4'b1010;

  typedef enum logic [2:0] {
    OP_INMODE  = 3'd0,
    OP_PHANTOM = 3'd1,
    OP_MUTE    = 3'd2,
    OP_RATE    = 3'd3,
    OP_EXTCLK  = 3'd4,
    OP_CLKLOAD = 3'd5
  } opT;

  typedef enum logic [1:0] {
    REG_SYS = 2'd0,
    REG_MON = 2'd1,
    REG_CLK = 2'd2
  } regSelT;

  typedef struct packed {
    regSelT           sel;
    logic [REG_W-1:0] data;
  } regWriteT;

  typedef struct packed {
    logic              latchPlan;
    logic              commit;
    logic              initMode;
    logic [SLOT_W-1:0] slot;
  } strobeT;

  function automatic regWriteT initWrite(input logic [SLOT_W-1:0] idx);
    regWriteT w;
    case (idx)
      2'd0:    begin w.sel = REG_SYS; w.data = SYS_PHOFF; end
      2'd1:    begin w.sel = REG_SYS; w.data = SYS_PHOFF | SYS_PWRUP; end
      2'd2:    begin w.sel = REG_MON; w.data = '0; end
      default: begin w.sel = REG_CLK; w.data = '0; end
    endcase
    return w;
  endfunction

  function automatic logic [31:0] rateHz(input logic [2:0] code);
    case (code)
      3'd0:    return 32'd44100;
      3'd1:    return 32'd48000;
      3'd2:    return 32'd88200;
      3'd3:    return 32'd96000;
      3'd4:    return 32'd176400;
      default: return 32'd192000;
    endcase
  endfunction

  function automatic logic [3:0] speedFor(input logic [31:0] hz);
    if (hz > 32'd108000)     return SPEED_QUAD;
    else if (hz > 32'd54000) return SPEED_DOUBLE;
    else                     return SPEED_NORMAL;
  endfunction

endpackage

// File: rtl/audio_ctl_seq_ctrl.sv
module audio_ctl_seq_ctrl
  import audio_ctl_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmdValid,
  input  logic [1:0] reqCount,
  input  logic       wrReady,
  output logic       cmdReady,
  output logic       wrValid,
  output strobeT     strobes
);

  typedef enum logic [1:0] {ST_INIT, ST_IDLE, ST_ISSUE} stateT;

  localparam logic [SLOT_W-1:0] LAST_INIT = SLOT_W'(INIT_STEPS - 1);

  stateT             state;
  logic [SLOT_W-1:0] slotR;
  logic              lastR;
  logic              accept;
  logic              fire;

  always_comb begin
    cmdReady          = (state == ST_IDLE);
    wrValid           = (state != ST_IDLE);
    accept            = cmdValid && cmdReady;
    fire              = wrValid && wrReady;
    strobes.latchPlan = accept;
    strobes.commit    = fire;
    strobes.initMode  = (state == ST_INIT);
    strobes.slot      = slotR;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_INIT;
      slotR <= '0;
      lastR <= 1'b0;
    end else begin
      case (state)
        ST_INIT: begin
          if (fire) begin
            if (slotR == LAST_INIT) begin
              state <= ST_IDLE;
              slotR <= '0;
            end else begin
              slotR <= slotR + 1'b1;
            end
          end
        end
        ST_IDLE: begin
          if (accept && reqCount != 2'd0) begin
            state <= ST_ISSUE;
            slotR <= '0;
            lastR <= (reqCount == 2'd2);
          end
        end
        default: begin
          if (fire) begin
            if (slotR[0] == lastR) begin
              state <= ST_IDLE;
              slotR <= '0;
            end else begin
              slotR <= slotR + 1'b1;
            end
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/audio_ctl_seq_datapath.sv
module audio_ctl_seq_datapath
  import audio_ctl_seq_pkg::*;
#(
  parameter int HZ_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  strobeT           strobes,
  input  logic [2:0]       cmdOp,
  input  logic [REG_W-1:0] cmdArg,
  input  logic             extRateValid,
  input  logic [HZ_W-1:0]  extRateHz,
  output logic [1:0]       reqCount,
  output logic [1:0]       wrSel,
  output logic [REG_W-1:0] wrData,
  output logic [3:0]       codecSpeed,
  output logic             clkCfgErr
);

  logic [REG_W-1:0] sysR;
  logic [REG_W-1:0] clkR;
  logic [3:0]       speedR;
  regWriteT         planR [2];

  regWriteT         step0;
  regWriteT         step1;
  logic             spdUpd;
  logic [3:0]       spdVal;
  logic [1:0]       tgt;
  logic [REG_W-1:0] nv;
  regWriteT         curW;
  logic             extMaster;

  // plan the write pair for the offered command
  always_comb begin
    reqCount   = 2'd0;
    step0.sel  = REG_SYS;
    step0.data = sysR;
    step1.sel  = REG_SYS;
    step1.data = sysR;
    spdUpd     = 1'b0;
    spdVal     = speedR;
    tgt        = 2'b00;
    nv         = sysR;
    case (cmdOp)
      OP_INMODE: begin
        if (cmdArg[1:0] != 2'd3) begin
          tgt = (cmdArg[1:0] == 2'd2) ? 2'b11 : cmdArg[1:0];
          if (tgt != sysR[5:4]) begin
            reqCount = 2'd2;
            if (tgt == 2'b00) begin
              step0.data = sysR & ~SYS_SRC;
              step1.data = step0.data & ~SYS_RELAY;
            end else begin
              step0.data = sysR | SYS_RELAY;
              step1.data = (step0.data & ~SYS_SRC) | {2'b00, tgt, 4'b0000};
            end
          end
        end
      end
      OP_PHANTOM: begin
        if (cmdArg[0] != sysR[1]) begin
          reqCount = 2'd2;
          if (cmdArg[0]) begin
            step0.data = sysR | SYS_PVOLT;
            step1.data = step0.data & ~SYS_PHOFF;
          end else begin
            step0.data = sysR & ~SYS_PVOLT;
            step1.data = step0.data | SYS_PHOFF;
          end
        end
      end
      OP_MUTE: begin
        nv = cmdArg[0] ? (sysR | SYS_MUTE) : (sysR & ~SYS_MUTE);
        if (nv != sysR) begin
          reqCount   = 2'd1;
          step0.data = nv;
        end
      end
      OP_RATE: begin
        if (cmdArg[2:0] <= 3'd5) begin
          spdUpd    = 1'b1;
          spdVal    = speedFor(rateHz(cmdArg[2:0]));
          nv        = (clkR & ~(CLK_RATE | CLK_SYNC)) | {5'b00000, cmdArg[2:0]};
          step0.sel = REG_CLK;
          step0.data = nv;
          if (nv != clkR) reqCount = 2'd1;
        end
      end
      OP_EXTCLK: begin
        if (cmdArg[1:0] != 2'd3) begin
          case (cmdArg[1:0])
            2'd0:    nv = (clkR & ~(CLK_RATE | CLK_WSEL)) | EXT_SPDIF;
            2'd1:    nv = (clkR & ~(CLK_RATE | CLK_WSEL)) | EXT_WC1;
            default: nv = (clkR & ~(CLK_RATE | CLK_WSEL)) | EXT_WC256;
          endcase
          step0.sel  = REG_CLK;
          step0.data = nv;
          if (nv != clkR) reqCount = 2'd1;
        end
      end
      OP_CLKLOAD: begin
        step0.sel  = REG_CLK;
        step0.data = cmdArg;
        if (cmdArg != clkR) reqCount = 2'd1;
      end
      default: ;
    endcase
  end

  // current request: fixed power-up table or the latched plan
  always_comb begin
    if (strobes.initMode) curW = initWrite(strobes.slot);
    else                  curW = planR[strobes.slot[0]];
    wrSel  = curW.sel;
    wrData = curW.data;
  end

  assign extMaster  = ((clkR & CLK_KEY) == EXT_SPDIF);
  assign clkCfgErr  = ((clkR & CLK_SYNC) != '0) &&
                      ((clkR & CLK_KEY) != EXT_SPDIF) &&
                      ((clkR & CLK_KEY) != EXT_WC1) &&
                      ((clkR & CLK_KEY) != EXT_WC256);
  assign codecSpeed = speedR;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      planR[0] <= '0;
      planR[1] <= '0;
    end else if (strobes.latchPlan) begin
      planR[0] <= step0;
      planR[1] <= step1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sysR <= '0;
      clkR <= '0;
    end else if (strobes.commit) begin
      case (curW.sel)
        REG_SYS: sysR <= curW.data;
        REG_CLK: clkR <= curW.data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      speedR <= SPEED_NORMAL;
    end else if (strobes.latchPlan && spdUpd) begin
      speedR <= spdVal;
    end else if (extRateValid && extMaster && extRateHz != '0) begin
      speedR <= speedFor(32'(extRateHz));
    end
  end

endmodule

// File: rtl/audio_ctl_sequencer.sv
module audio_ctl_sequencer
  import audio_ctl_seq_pkg::*;
#(
  parameter int HZ_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmdValid,
  input  logic [2:0]       cmdOp,
  input  logic [7:0]       cmdArg,
  output logic             cmdReady,
  input  logic             extRateValid,
  input  logic [HZ_W-1:0]  extRateHz,
  output logic             wrValid,
  input  logic             wrReady,
  output logic [1:0]       wrSel,
  output logic [7:0]       wrData,
  output logic [3:0]       codecSpeed,
  output logic             clkCfgErr
);

  strobeT     strobes;
  logic [1:0] reqCount;

  audio_ctl_seq_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmdValid (cmdValid),
    .reqCount (reqCount),
    .wrReady  (wrReady),
    .cmdReady (cmdReady),
    .wrValid  (wrValid),
    .strobes  (strobes)
  );

  audio_ctl_seq_datapath #(.HZ_W(HZ_W)) u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .strobes      (strobes),
    .cmdOp        (cmdOp),
    .cmdArg       (cmdArg),
    .extRateValid (extRateValid),
    .extRateHz    (extRateHz),
    .reqCount     (reqCount),
    .wrSel        (wrSel),
    .wrData       (wrData),
    .codecSpeed   (codecSpeed),
    .clkCfgErr    (clkCfgErr)
  );

endmodule

// File: rtl/audio_ctl_sequencer_chk.sv
module audio_ctl_sequencer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmdReady,
  input logic       wrValid,
  input logic       wrReady,
  input logic [1:0] wrSel,
  input logic [7:0] wrData,
  input logic [3:0] codecSpeed
);

  // R2: reserved mode code never leaves the block
  a_r2_no_reserved_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (wrValid && wrSel == 2'd0) |-> (wrData[5:4] != 2'b10));

  // R3: any mic source selection is written with the relay already set
  a_r3_relay_guards_source: assert property (@(posedge clk) disable iff (!rst_n)
    (wrValid && wrSel == 2'd0) |-> (wrData[5:4] == 2'b00 || wrData[0]));

  // R10: stalled request holds steady
  a_r10_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (wrValid && !wrReady) |=> (wrValid && $stable(wrData) && $stable(wrSel)));

  // R10: no new command while a write is pending
  a_r10_ready_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmdReady && wrValid));

  // R8: only the three speed codes
  a_r8_speed_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (codecSpeed == 4'b0000 || codecSpeed == 4'b0101 || codecSpeed == 4'b1010));

endmodule

bind audio_ctl_sequencer audio_ctl_sequencer_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmdReady   (cmdReady),
  .wrValid    (wrValid),
  .wrReady    (wrReady),
  .wrSel      (wrSel),
  .wrData     (wrData),
  .codecSpeed (codecSpeed)
);

// File: tb/audio_ctl_sequencer_bench.sv
module audio_ctl_sequencer_bench;

  localparam int HZ_W = 18;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cmdValid = 1'b0;
  logic [2:0]      cmdOp = '0;
  logic [7:0]      cmdArg = '0;
  logic            cmdReady;
  logic            extRateValid = 1'b0;
  logic [HZ_W-1:0] extRateHz = '0;
  logic            wrValid;
  logic            wrReady = 1'b0;
  logic [1:0]      wrSel;
  logic [7:0]      wrData;
  logic [3:0]      codecSpeed;
  logic            clkCfgErr;

  int tests = 0;
  int fails = 0;
  int readyCnt = 0;

  logic [9:0] expQ[$];
  string      tagQ[$];

  logic [7:0] sysM = 8'h88;
  logic [7:0] clkM = 8'h00;
  logic [3:0] speedM = 4'b0000;

  audio_ctl_sequencer #(.HZ_W(HZ_W)) u_audio_ctl_sequencer (
    .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdArg(cmdArg),
    .cmdReady(cmdReady), .extRateValid(extRateValid), .extRateHz(extRateHz),
    .wrValid(wrValid), .wrReady(wrReady), .wrSel(wrSel), .wrData(wrData),
    .codecSpeed(codecSpeed), .clkCfgErr(clkCfgErr)
  );

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic expectWrite(input logic [1:0] sel, input logic [7:0] data, input string tag);
    expQ.push_back({sel, data});
    tagQ.push_back(tag);
  endtask

  function automatic logic [3:0] speedOf(input int hz);
    if (hz > 108000) return 4'b1010;
    if (hz > 54000)  return 4'b0101;
    return 4'b0000;
  endfunction

  function automatic bit errOf(input logic [7:0] c);
    logic [7:0] k;
    k = c & 8'h1F;
    return c[3] && !(k == 8'h08 || k == 8'h0A || k == 8'h1A);
  endfunction

  // monitor: pops an expected write for each accepted request
  initial begin
    forever begin
      @(negedge clk);
      readyCnt++;
      wrReady = (readyCnt % 3) != 0;
      #1;
      if (rst_n && wrValid && wrReady) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R9 unexpected write", {wrSel, wrData}, 0);
        end else begin
          logic [9:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          check({wrSel, wrData} == e, t, {wrSel, wrData}, e);
        end
      end
    end
  end

  task automatic waitIdle(input string tag);
    do @(negedge clk); while (!cmdReady);
    check(expQ.size() == 0, tag, expQ.size(), 0);
    check(codecSpeed == speedM, "R8 speed", codecSpeed, speedM);
    check(clkCfgErr == errOf(clkM), "R11 error flag", clkCfgErr, errOf(clkM));
  endtask

  task automatic sendCmd(input logic [2:0] op, input logic [7:0] arg, input int nExp, input string tag);
    do @(negedge clk); while (!cmdReady);
    cmdValid = 1'b1;
    cmdOp    = op;
    cmdArg   = arg;
    @(negedge clk);
    cmdValid = 1'b0;
    if (nExp == 0) check(cmdReady && !wrValid, {"R9 no write ", tag}, {cmdReady, wrValid}, 2);
    else           check(!cmdReady && wrValid, {"R10 busy ", tag}, {cmdReady, wrValid}, 1);
    waitIdle(tag);
  endtask

  task automatic opInMode(input logic [1:0] arg);
    logic [1:0] tgt;
    logic [7:0] w1, w2;
    int n;
    n = 0;
    if (arg != 2'd3) begin
      tgt = (arg == 2'd2) ? 2'b11 : arg;
      if (tgt != sysM[5:4]) begin
        if (tgt == 2'b00) begin w1 = sysM & ~8'h30; w2 = w1 & ~8'h01; end
        else begin w1 = sysM | 8'h01; w2 = (w1 & ~8'h30) | {2'b00, tgt, 4'b0000}; end
        expectWrite(2'd0, w1, "R3 first step");
        expectWrite(2'd0, w2, "R3 second step");
        sysM = w2;
        n = 2;
      end
    end
    sendCmd(3'd0, {6'd0, arg}, n, "R2 input mode");
  endtask

  task automatic opPhantom(input bit on);
    logic [7:0] w1, w2;
    int n;
    n = 0;
    if (on != sysM[1]) begin
      if (on) begin w1 = sysM | 8'h02; w2 = w1 & ~8'h08; end
      else    begin w1 = sysM & ~8'h02; w2 = w1 | 8'h08; end
      expectWrite(2'd0, w1, "R4 voltage step");
      expectWrite(2'd0, w2, "R4 enable step");
      sysM = w2;
      n = 2;
    end
    sendCmd(3'd1, {7'd0, on}, n, "R4 phantom");
  endtask

  task automatic opMute(input bit m);
    logic [7:0] nv;
    int n;
    n = 0;
    nv = m ? (sysM | 8'h04) : (sysM & ~8'h04);
    if (nv != sysM) begin expectWrite(2'd0, nv, "R5 mute"); sysM = nv; n = 1; end
    sendCmd(3'd2, {7'd0, m}, n, "R5 mute");
  endtask

  task automatic opRate(input logic [2:0] idx);
    int hz[6] = '{44100, 48000, 88200, 96000, 176400, 192000};
    logic [7:0] nv;
    int n;
    n = 0;
    if (idx <= 3'd5) begin
      speedM = speedOf(hz[idx]);
      nv = (clkM & ~8'h0F) | {5'd0, idx};
      if (nv != clkM) begin expectWrite(2'd2, nv, "R6 rate"); clkM = nv; n = 1; end
    end
    sendCmd(3'd3, {5'd0, idx}, n, "R6 rate");
  endtask

  task automatic opExt(input logic [1:0] src);
    logic [7:0] code[3] = '{8'h08, 8'h0A, 8'h1A};
    logic [7:0] nv;
    int n;
    n = 0;
    if (src != 2'd3) begin
      nv = (clkM & ~8'h17) | code[src];
      if (nv != clkM) begin expectWrite(2'd2, nv, "R7 external"); clkM = nv; n = 1; end
    end
    sendCmd(3'd4, {6'd0, src}, n, "R7 external");
  endtask

  task automatic opLoad(input logic [7:0] v);
    int n;
    n = 0;
    if (v != clkM) begin expectWrite(2'd2, v, "R11 restore"); clkM = v; n = 1; end
    sendCmd(3'd5, v, n, "R11 restore");
  endtask

  task automatic extReport(input int hz);
    @(negedge clk);
    extRateValid = 1'b1;
    extRateHz    = HZ_W'(hz);
    if ((clkM & 8'h1F) == 8'h08 && hz != 0) speedM = speedOf(hz);
    @(negedge clk);
    extRateValid = 1'b0;
    check(codecSpeed == speedM, "R8 receiver report", codecSpeed, speedM);
  endtask

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    expectWrite(2'd0, 8'h08, "R1 init step 0");
    expectWrite(2'd0, 8'h88, "R1 init step 1");
    expectWrite(2'd1, 8'h00, "R1 init step 2");
    expectWrite(2'd2, 8'h00, "R1 init step 3");
    repeat (3) @(negedge clk);
    check(cmdReady == 1'b0, "R1 reset ready", cmdReady, 0);
    check(codecSpeed == 4'b0000, "R1 reset speed", codecSpeed, 0);
    rst_n = 1'b1;
    waitIdle("R1 init done");

    opInMode(2'd1);
    opInMode(2'd2);
    opInMode(2'd3);
    opInMode(2'd2);
    opInMode(2'd0);
    opInMode(2'd2);
    opInMode(2'd0);

    opPhantom(1'b1);
    opPhantom(1'b1);
    opMute(1'b1);
    opMute(1'b1);
    opPhantom(1'b0);
    opMute(1'b0);

    opRate(3'd3);
    opRate(3'd5);
    opRate(3'd7);
    opRate(3'd2);
    opRate(3'd0);

    opExt(2'd0);
    extReport(100000);
    extReport(0);
    extReport(200000);
    opExt(2'd0);
    opExt(2'd2);
    extReport(50000);
    opExt(2'd3);
    opExt(2'd1);
    opRate(3'd1);

    opLoad(8'h0C);
    opLoad(8'h1A);
    opLoad(8'h3B);
    opLoad(8'h04);

    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R9 queue drained", expQ.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule